// File: doc/BRIEF.md
# Three-Channel Chainable Timer

This block holds three independent 16-bit up-counting waveform channels behind a single register window. Each channel picks a count source (the system clock, a slow tick pulse, or its external clock input). It can count freely or reload at a top value, and it can stop itself after one period. Each channel drives one waveform output and one interrupt line.

Two features tie the channels together. A block routing bit feeds the waveform output of channel 0, after resynchronisation and rising-edge detection, into the external clock input of channel 1. When channel 0 toggles its output once per wrap, channel 1 then counts wraps, and the pair forms a 32-bit free-running count. A block sync command restarts all three counters on the same clock edge. A read of channel 0's counter captures channel 1's counter into a shadow register, so the next read of channel 1 returns a value taken in the same cycle as the channel 0 value.

The third channel is meant for a tick timer on the slow clock. It runs periodically by reloading at its top value, or as a one-shot that halts when it reaches that value.

Top module: `triple_timer`

## Requirements
- R1: After reset, every counter, flag and interrupt-enable register reads 0. Every waveform output and interrupt line is low, and the routing bit reads 0.
- R2: Channel c occupies byte addresses c*0x20 to c*0x20+0x1F. Its registers sit at these offsets: command 0x00 (write-only), mode 0x04, counter 0x08 (read-only), compare A 0x0C, top 0x10, flags 0x14, interrupt enable 0x18. The block registers are sync 0x60 (write-only) and route 0x64. Mode (6 bits), compare A and top (counter width) and interrupt enable (3 bits) read back exactly what was written, truncated to their width.
- R3: Mode bits [1:0] select the count source: 0 = every system clock edge, 1 = slow_tick pulses, 2 = external input, 3 = none. A running channel on source 0 in free-run mode (mode bit 2 clear) advances by one per edge and wraps from all ones to 0. That wrap sets flag bit 2.
- R4: Command bit 0 starts the channel and command bit 1 stops it; stop wins when both are set. Command bit 2 clears the counter and the waveform output on that edge. A stopped channel holds its count.
- R5: Writing bit 0 of the sync register clears all three counters on the same edge. Channel 0 running on source 0 then reads n mod 2^W when n edges have passed since the sync edge.
- R6: With route bit 0 set and channel 1 on source 2, channel 1 advances on the 3rd edge after each edge that raises channel 0's waveform output. With the route bit clear, channel 1's external input never advances it.
- R7: A count step taken while the counter equals compare A sets the waveform output when mode bit 4 is set. A step taken while it equals top clears the output when mode bit 5 is set.
- R8: With mode bit 2 set, a step taken at the top value reloads the counter to 0 and sets flag bit 1, so the period is top+1 steps. Source 1 takes one step per slow_tick pulse.
- R9: With mode bit 3 set, a step at the top value also stops the channel (flag bit 3 reads 0 afterwards).
- R10: The flags register reads {running, overflow, top hit, compare A hit} in bits [3:0]. Bits [2:0] are sticky and clear on a read, and a new event in the same cycle wins over the clear. irq[c] is high while flags[2:0] AND the enable register [2:0] is non-zero.
- R11: A read of channel 0's counter captures channel 1's counter. The next read of channel 1's counter returns that captured value and consumes it. A channel 1 counter read with no pending capture returns the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (applies read side effects) |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from addr |
| slow_tick | input | 1 | One-cycle pulse per slow clock period |
| wave_out | output | 3 | Waveform output of each channel |
| irq | output | 3 | Interrupt line of each channel |

## Verification
Read data is combinational, so the bench samples it just after the falling edge. The value seen is the state after the last rising edge, and read side effects (flag clear, shadow capture) land on the rising edge that follows. Writes take effect on the rising edge where the strobe is sampled. The bench records that edge number and predicts counts as edges elapsed since then, so a counter on the system clock reads n mod 2^W. A channel 1 value driven by chaining is predicted with its fixed 3-edge delay behind channel 0's waveform rise: 0 before edge 4, then (n-4)/2^W+1. The expected interrupt state is checked right after the slow tick pulse that completes a period and right after the flag read that clears it.

// File: rtl/triple_timer_pkg.sv
package triple_timer_pkg;

    localparam int NUM_CH    = 3;
    localparam int EVT_W     = 3;
    localparam int MODE_W    = 6;
    localparam int SEL_W     = 2;
    localparam int OFF_W     = 5;
    localparam int CHAIN_SRC = 0;
    localparam int CHAIN_DST = 1;

    // command bits
    localparam int CMD_START   = 0;
    localparam int CMD_STOP    = 1;
    localparam int CMD_RESTART = 2;

    // register offsets inside a channel window
    localparam logic [OFF_W-1:0] OFF_CMD   = 5'h00;
    localparam logic [OFF_W-1:0] OFF_MODE  = 5'h04;
    localparam logic [OFF_W-1:0] OFF_COUNT = 5'h08;
    localparam logic [OFF_W-1:0] OFF_CMPA  = 5'h0C;
    localparam logic [OFF_W-1:0] OFF_TOP   = 5'h10;
    localparam logic [OFF_W-1:0] OFF_FLAGS = 5'h14;
    localparam logic [OFF_W-1:0] OFF_IEN   = 5'h18;

    // block window
    localparam logic [SEL_W-1:0] BLK_SEL   = 2'd3;
    localparam logic [OFF_W-1:0] OFF_SYNC  = 5'h00;
    localparam logic [OFF_W-1:0] OFF_ROUTE = 5'h04;

    typedef enum logic [1:0] {
        SRC_SYS  = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_NONE = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic     clr_out_top;
        logic     set_out_a;
        logic     stop_top;
        logic     reload_top;
        clk_src_e src;
    } mode_t;

endpackage

// File: rtl/triple_timer_edge_sync.sv
module triple_timer_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], level_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/triple_timer_chan.sv
module triple_timer_chan
    import triple_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_cmd_i,
    input  logic              wr_mode_i,
    input  logic              wr_cmpa_i,
    input  logic              wr_top_i,
    input  logic              wr_ien_i,
    input  logic              rd_flags_i,
    input  logic              sync_i,
    input  logic              slow_tick_i,
    input  logic              ext_tick_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  cmpa_o,
    output logic [CNT_W-1:0]  top_o,
    output mode_t             mode_o,
    output logic [EVT_W-1:0]  ien_o,
    output logic [EVT_W:0]    flags_o,
    output logic              wave_o,
    output logic              irq_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmpa;
        logic [CNT_W-1:0] top;
        mode_t            mode;
        logic [EVT_W-1:0] ien;
        logic [EVT_W-1:0] flags;
        logic             run;
        logic             wave;
    } chan_st_t;

    chan_st_t         st_d, st_q;
    logic             restart;
    logic             src_pulse;
    logic             tick;
    logic             hit_a;
    logic             hit_top;
    logic             wrap;
    logic [EVT_W-1:0] events;

    always_comb begin
        st_d    = st_q;
        restart = sync_i | (wr_cmd_i & wdata_i[CMD_RESTART]);

        unique case (st_q.mode.src)
            SRC_SYS:  src_pulse = 1'b1;
            SRC_SLOW: src_pulse = slow_tick_i;
            SRC_EXT:  src_pulse = ext_tick_i;
            default:  src_pulse = 1'b0;
        endcase

        tick    = st_q.run & src_pulse & ~restart;
        hit_a   = tick & (st_q.cnt == st_q.cmpa);
        hit_top = tick & (st_q.cnt == st_q.top);
        wrap    = tick & (st_q.cnt == CNT_MAX) & ~(st_q.mode.reload_top & hit_top);
        events  = {wrap, hit_top, hit_a};

        if (restart) begin
            st_d.cnt  = '0;
            st_d.wave = 1'b0;
        end else if (tick) begin
            if (st_q.mode.reload_top && hit_top) st_d.cnt = '0;
            else                                 st_d.cnt = st_q.cnt + 1'b1;
            if (hit_a && st_q.mode.set_out_a)      st_d.wave = 1'b1;
            if (hit_top && st_q.mode.clr_out_top)  st_d.wave = 1'b0;
            if (hit_top && st_q.mode.stop_top)     st_d.run  = 1'b0;
        end

        if (wr_cmd_i) begin
            if (wdata_i[CMD_START]) st_d.run = 1'b1;
            if (wdata_i[CMD_STOP])  st_d.run = 1'b0;
        end

        if (rd_flags_i) st_d.flags = '0;
        st_d.flags = st_d.flags | events;

        if (wr_mode_i) st_d.mode = mode_t'(wdata_i[MODE_W-1:0]);
        if (wr_cmpa_i) st_d.cmpa = wdata_i[CNT_W-1:0];
        if (wr_top_i)  st_d.top  = wdata_i[CNT_W-1:0];
        if (wr_ien_i)  st_d.ien  = wdata_i[EVT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign cmpa_o  = st_q.cmpa;
    assign top_o   = st_q.top;
    assign mode_o  = st_q.mode;
    assign ien_o   = st_q.ien;
    assign flags_o = {st_q.run, st_q.flags};
    assign wave_o  = st_q.wave;
    assign irq_o   = |(st_q.flags & st_q.ien);

    // R4
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0) && !st_q.wave);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !restart) |=> $stable(st_q.cnt));

    // R9
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (st_q.cnt == st_q.top) && st_q.mode.stop_top
         && !(wr_cmd_i && wdata_i[CMD_START])) |=> !st_q.run);

    // R10
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags_i && (events == '0)) |=> (st_q.flags == '0));

    // R3
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (st_q.cnt == CNT_MAX) && !st_q.mode.reload_top) |=> st_q.flags[2]);

endmodule

// File: rtl/triple_timer.sv
module triple_timer
    import triple_timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              slow_tick,
    output logic [NUM_CH-1:0] wave_out,
    output logic [NUM_CH-1:0] irq
);

    typedef struct packed {
        logic             route;
        logic [CNT_W-1:0] shadow;
        logic             shadow_vld;
    } blk_st_t;

    blk_st_t          blk_d, blk_q;
    logic [SEL_W-1:0] sel;
    logic [OFF_W-1:0] off;
    logic             blk_hit;
    logic             sync_go;
    logic             wr_route;
    logic             rd_cnt0;
    logic             rd_cnt1;
    logic             chain_rise;

    logic [CNT_W-1:0] cnt   [NUM_CH];
    logic [CNT_W-1:0] cmpa  [NUM_CH];
    logic [CNT_W-1:0] top   [NUM_CH];
    mode_t            mode  [NUM_CH];
    logic [EVT_W-1:0] ien   [NUM_CH];
    logic [EVT_W:0]   flags [NUM_CH];
    logic [NUM_CH-1:0] ch_hit;
    logic [NUM_CH-1:0] ext_tick;

    assign sel      = addr[OFF_W+SEL_W-1:OFF_W];
    assign off      = addr[OFF_W-1:0];
    assign blk_hit  = (sel == BLK_SEL);
    assign sync_go  = wr_en & blk_hit & (off == OFF_SYNC) & wdata[0];
    assign wr_route = wr_en & blk_hit & (off == OFF_ROUTE);
    assign rd_cnt0  = rd_en & ch_hit[CHAIN_SRC] & (off == OFF_COUNT);
    assign rd_cnt1  = rd_en & ch_hit[CHAIN_DST] & (off == OFF_COUNT);

    triple_timer_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_chain_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (wave_out[CHAIN_SRC]),
        .rise_o  (chain_rise)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_hit[c] = (int'(sel) == c);

        if (c == CHAIN_DST) begin : g_chained
            assign ext_tick[c] = chain_rise & blk_q.route;
        end else begin : g_plain
            assign ext_tick[c] = 1'b0;
        end

        triple_timer_chan #(
            .CNT_W  (CNT_W),
            .DATA_W (DATA_W)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .wdata_i     (wdata),
            .wr_cmd_i    (wr_en & ch_hit[c] & (off == OFF_CMD)),
            .wr_mode_i   (wr_en & ch_hit[c] & (off == OFF_MODE)),
            .wr_cmpa_i   (wr_en & ch_hit[c] & (off == OFF_CMPA)),
            .wr_top_i    (wr_en & ch_hit[c] & (off == OFF_TOP)),
            .wr_ien_i    (wr_en & ch_hit[c] & (off == OFF_IEN)),
            .rd_flags_i  (rd_en & ch_hit[c] & (off == OFF_FLAGS)),
            .sync_i      (sync_go),
            .slow_tick_i (slow_tick),
            .ext_tick_i  (ext_tick[c]),
            .cnt_o       (cnt[c]),
            .cmpa_o      (cmpa[c]),
            .top_o       (top[c]),
            .mode_o      (mode[c]),
            .ien_o       (ien[c]),
            .flags_o     (flags[c]),
            .wave_o      (wave_out[c]),
            .irq_o       (irq[c])
        );
    end

    always_comb begin
        blk_d = blk_q;
        if (wr_route) blk_d.route = wdata[0];
        if (rd_cnt1)  blk_d.shadow_vld = 1'b0;
        if (rd_cnt0) begin
            blk_d.shadow     = cnt[CHAIN_DST];
            blk_d.shadow_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) blk_q <= '0;
        else        blk_q <= blk_d;
    end

    always_comb begin
        rdata = '0;
        if (blk_hit) begin
            if (off == OFF_ROUTE) rdata = DATA_W'(blk_q.route);
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (ch_hit[c]) begin
                    unique case (off)
                        OFF_MODE:  rdata = DATA_W'(mode[c]);
                        OFF_CMPA:  rdata = DATA_W'(cmpa[c]);
                        OFF_TOP:   rdata = DATA_W'(top[c]);
                        OFF_FLAGS: rdata = DATA_W'(flags[c]);
                        OFF_IEN:   rdata = DATA_W'(ien[c]);
                        OFF_COUNT: begin
                            if (c == CHAIN_DST && blk_q.shadow_vld) rdata = DATA_W'(blk_q.shadow);
                            else                                     rdata = DATA_W'(cnt[c]);
                        end
                        default:   rdata = '0;
                    endcase
                end
            end
        end
    end

    // R5
    sync_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_go |=> (cnt[0] == '0) && (cnt[1] == '0) && (cnt[2] == '0));

    // R11
    shadow_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt0 |=> blk_q.shadow_vld && (blk_q.shadow == $past(cnt[CHAIN_DST])));

endmodule

// File: tb/triple_timer_tb_top.sv
module triple_timer_tb_top;

    localparam int W = 8;
    localparam int unsigned P = 1 << W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        slow_tick = 1'b0;
    logic [2:0]  wave_out;
    logic [2:0]  irq;

    triple_timer #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .slow_tick(slow_tick),
        .wave_out(wave_out), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int unsigned evt_at;
    int unsigned sync_at;

    function automatic logic [7:0] ra(input int ch, input logic [4:0] off);
        return 8'(ch * 32) | {3'b0, off};
    endfunction

    function automatic int unsigned exp_ch1(input int unsigned n);
        return (n < 4) ? 0 : (((n - 4) / P + 1) % P);
    endfunction

    function automatic logic exp_wave0(input int unsigned n);
        int unsigned v;
        v = n % P;
        return (v >= 1) && (v <= P / 2);
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
        evt_at = cyc;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output int unsigned at);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata; at = cyc;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic pulse_slow();
        @(negedge clk) slow_tick = 1'b1;
        @(negedge clk) slow_tick = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2;
        int unsigned at, at2, n0;
        logic [31:0] v;
        void'($urandom(32'd4711));

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int c = 0; c < 3; c++) begin
            rd(ra(c, 5'h08), d, at); check("R1", "count after reset", d, 0);
            rd(ra(c, 5'h14), d, at); check("R1", "flags after reset", d, 0);
            rd(ra(c, 5'h18), d, at); check("R1", "irq enable after reset", d, 0);
        end
        rd(8'h64, d, at); check("R1", "route after reset", d, 0);
        check("R1", "wave after reset", {29'b0, wave_out}, 0);
        check("R1", "irq after reset", {29'b0, irq}, 0);

        // R2 readback with width truncation
        for (int i = 0; i < 4; i++) begin
            v = $urandom();
            wr(ra(2, 5'h04), v); rd(ra(2, 5'h04), d, at); check("R2", "mode readback", d, v & 32'h3F);
            v = $urandom();
            wr(ra(2, 5'h0C), v); rd(ra(2, 5'h0C), d, at); check("R2", "compare A readback", d, v & (P - 1));
            v = $urandom();
            wr(ra(2, 5'h10), v); rd(ra(2, 5'h10), d, at); check("R2", "top readback", d, v & (P - 1));
            v = $urandom();
            wr(ra(2, 5'h18), v); rd(ra(2, 5'h18), d, at); check("R2", "irq enable readback", d, v & 32'h7);
        end
        wr(ra(2, 5'h04), 0); wr(ra(2, 5'h0C), 0); wr(ra(2, 5'h10), 0); wr(ra(2, 5'h18), 0);
        rd(ra(2, 5'h14), d, at);

        // chain setup, then R5 sync on the edge after channel 0 starts
        wr(8'h64, 1);
        wr(ra(1, 5'h04), 32'h02);
        wr(ra(1, 5'h00), 32'h1);
        wr(ra(2, 5'h00), 32'h1);
        wr(ra(0, 5'h0C), 0);
        wr(ra(0, 5'h10), P / 2);
        wr(ra(0, 5'h04), 32'h30);
        wr(ra(0, 5'h00), 32'h1);
        wr(8'h60, 32'h1);
        sync_at = evt_at;

        rd(ra(0, 5'h08), d, at); check("R5", "ch0 right after sync", d, (at - sync_at) % P);
        rd(ra(1, 5'h08), d, at2); check("R6", "ch1 right after sync", d, exp_ch1(at - sync_at));
        rd(ra(2, 5'h08), d, at); check("R5", "ch2 right after sync", d, (at - sync_at) % P);

        // random sampling of the 2W-bit pair (R3, R6, R7, R11)
        for (int i = 0; i < 16; i++) begin
            repeat ($urandom_range(1, 150)) @(posedge clk);
            rd(ra(0, 5'h08), d, at);
            n0 = at - sync_at;
            check("R3", "ch0 free-run count", d, n0 % P);
            rd(ra(1, 5'h08), d, at2);
            check("R11", "ch1 paired with ch0", d, exp_ch1(n0));
            rd(ra(2, 5'h08), d, at);
            check("R5", "ch2 count since sync", d, (at - sync_at) % P);
            @(negedge clk); #1;
            check("R7", "ch0 waveform level", {31'b0, wave_out[0]}, {31'b0, exp_wave0(cyc - sync_at)});
        end

        repeat (300) @(posedge clk);
        rd(ra(2, 5'h14), d, at);
        check("R3", "ch2 overflow flag", d & 32'hC, 32'hC);

        // R11 stale capture, then live read
        rd(ra(0, 5'h08), d, at);
        n0 = at - sync_at;
        repeat (300) @(posedge clk);
        rd(ra(1, 5'h08), d, at);
        check("R11", "captured ch1 after delay", d, exp_ch1(n0));
        rd(ra(1, 5'h08), d, at);
        check("R11", "live ch1 after capture used", d, exp_ch1(at - sync_at));

        // R6 route cleared: channel 1 frozen
        wr(8'h64, 0);
        rd(ra(1, 5'h08), d, at);
        repeat (600) @(posedge clk);
        rd(ra(1, 5'h08), d2, at);
        check("R6", "ch1 frozen with route clear", d2, d);

        // R4 commands on channel 2
        wr(ra(2, 5'h00), 32'h3);
        rd(ra(2, 5'h08), d, at);
        repeat (40) @(posedge clk);
        rd(ra(2, 5'h08), d2, at);
        check("R4", "stop wins over start", d2, d);
        rd(ra(2, 5'h14), d, at);
        check("R4", "running flag clear", d & 32'h8, 0);
        wr(ra(2, 5'h00), 32'h4);
        rd(ra(2, 5'h08), d, at);
        check("R4", "restart clears count", d, 0);
        wr(ra(2, 5'h00), 32'h1);
        repeat ($urandom_range(5, 90)) @(posedge clk);
        rd(ra(2, 5'h08), d, at);
        check("R4", "count after start", d, (at - evt_at) % P);

        // R8 periodic reload on slow ticks, R10 interrupt
        begin
            int unsigned top_v, k;
            top_v = $urandom_range(2, 9);
            wr(ra(2, 5'h00), 32'h2);
            wr(ra(2, 5'h04), 32'h05);
            wr(ra(2, 5'h10), top_v);
            wr(ra(2, 5'h18), 32'h2);
            wr(ra(2, 5'h00), 32'h5);
            rd(ra(2, 5'h14), d, at);
            k = $urandom_range(1, top_v);
            for (int i = 0; i < int'(k); i++) pulse_slow();
            rd(ra(2, 5'h08), d, at);
            check("R8", "slow tick count", d, k);
            check("R10", "irq low before top", {31'b0, irq[2]}, 0);
            for (int i = int'(k); i <= int'(top_v); i++) pulse_slow();
            rd(ra(2, 5'h08), d, at);
            check("R8", "reload to 0 at top", d, 0);
            check("R10", "irq high after top hit", {31'b0, irq[2]}, 1);
            rd(ra(2, 5'h14), d, at);
            check("R10", "flags show top hit and running", d & 32'hA, 32'hA);
            check("R10", "irq cleared by flag read", {31'b0, irq[2]}, 0);
            rd(ra(2, 5'h14), d, at);
            check("R10", "sticky bits cleared", d & 32'h7, 0);
        end

        // R9 one-shot
        begin
            int unsigned top_v;
            top_v = $urandom_range(5, 40);
            wr(ra(2, 5'h04), 32'h0C);
            wr(ra(2, 5'h10), top_v);
            wr(ra(2, 5'h00), 32'h5);
            repeat (100) @(posedge clk);
            rd(ra(2, 5'h08), d, at);
            check("R9", "one-shot count parked", d, 0);
            rd(ra(2, 5'h14), d, at);
            check("R9", "one-shot stopped with top flag", d & 32'hA, 32'h2);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule